// File: doc/BRIEF.md
# Debug Breakpoint Comparator Unit

This block holds the hardware debug breakpoints of a processor core. It has a set of instruction-address breakpoints, switched on and off through one shared enable register, and a set of data breakpoints. Each data breakpoint has an address register and a control register. The control register holds two kind bits (one for stores, one for loads) and a low-order address mask. Software programs all of these through a simple write port.

Every cycle, the block compares the current instruction fetch address and the current load/store address against the armed breakpoints. The comparison is combinational from the current access and the stored registers. A hit is therefore seen in the same cycle as the access, before the access is allowed to complete. The block reports two things separately: an instruction-breakpoint hit with the index of the lowest-numbered matching breakpoint, and a data-breakpoint hit with its own lowest-numbered index. A combined debug request is raised when either kind hits.

The access inputs are plain per-cycle qualifiers rather than valid/ready streams. The block never stalls them, so there is no back-pressure. The core is expected to hold back any access that sees the debug request in the same cycle.

Top module: `dbg_bp_unit`

## Requirements
- R1: After reset no breakpoint is armed: dbg_req, ibp_hit and dbp_hit stay low for any fetch or data access.
- R2: An instruction breakpoint fires only while fetch_valid is high, its enable bit is set, and fetch_addr equals its address register in every bit.
- R3: A write to the enable register (cfg_addr 0x0) keeps only bits [NUM_IBP-1:0] of cfg_wdata, where bit i arms instruction breakpoint i. Higher data bits arm nothing.
- R4: When several instruction breakpoints match, ibp_idx gives the lowest-numbered one.
- R5: A data breakpoint is inactive while both of its kind bits are clear. The store bit is control bit 31 and the load bit is control bit 30.
- R6: The store bit matches only accesses with mem_write=1, and the load bit matches only accesses with mem_write=0. A hit also needs mem_valid.
- R7: Control bits [5:0] form the mask field, and mask bit j=1 means address bit j is compared. Address bits 31..6 are always compared. A hit needs (mem_addr & M) == (bp_addr & M), where M is the effective mask.
- R8: A mask field that is not a run of ones from bit 5 downward is cut at its first zero bit from the top. That bit and every bit below it are not compared, so the match region is a naturally aligned power-of-two block.
- R9: When several data breakpoints match, dbp_idx gives the lowest-numbered one.
- R10: A register write takes effect for accesses from the cycle after the write. An access in the write cycle itself still sees the old value.
- R11: dbg_req is high exactly when ibp_hit or dbp_hit is high, and both cause bits can be high in the same cycle.
- R12: Register map: 0x4+i is instruction address i, 0x8+i is data address i, and 0xC+i is data control i. A write to an index at or above the configured count changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| fetch_valid | input | 1 | Instruction fetch present this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| mem_valid | input | 1 | Load or store present this cycle |
| mem_write | input | 1 | 1 for store, 0 for load |
| mem_addr | input | 32 | Data access address |
| dbg_req | output | 1 | Debug request (any breakpoint hit) |
| ibp_hit | output | 1 | Instruction breakpoint hit |
| ibp_idx | output | 1 | Lowest matching instruction breakpoint |
| dbp_hit | output | 1 | Data breakpoint hit |
| dbp_idx | output | 1 | Lowest matching data breakpoint |

## Verification
The bench aims a non-contiguous mask at an address that differs from the breakpoint only in a bit below the cut. A design that compares the raw field misses that access, while a design that repairs the mask reports a hit. It writes all ones except the low enable bits, so a design that keeps too many enable bits arms a breakpoint. It sets two breakpoints to the same address, where a wrong priority order reports index 1 instead of 0. It also issues accesses of the wrong kind for a store-only or load-only breakpoint, and presents an access in the same cycle as the write that would make it match, which a design with a write bypass would flag early.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;
  localparam int ADDR_W = 32;
  localparam int MASK_W = 6;
  localparam int ST_BIT = 31;
  localparam int LD_BIT = 30;

  typedef enum logic [1:0] {
    SEL_IBP_EN   = 2'd0,
    SEL_IBP_ADDR = 2'd1,
    SEL_DBP_ADDR = 2'd2,
    SEL_DBP_CTRL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              st_en;
    logic              ld_en;
    logic [MASK_W-1:0] mask;
  } dbp_ctrl_t;
endpackage

// File: rtl/dbg_bp_regs.sv
module dbg_bp_regs
  import dbg_bp_pkg::*;
#(
  parameter int NUM_IBP = 2,
  parameter int NUM_DBP = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [3:0]                       cfg_addr,
  input  logic [31:0]                      cfg_wdata,
  output logic [NUM_IBP-1:0]               ibp_en,
  output logic [NUM_IBP-1:0][ADDR_W-1:0]   ibp_addr,
  output logic [NUM_DBP-1:0][ADDR_W-1:0]   dbp_addr,
  output dbp_ctrl_t [NUM_DBP-1:0]          dbp_ctrl
);
  reg_sel_e   sel;
  logic [1:0] idx;
  assign sel = reg_sel_e'(cfg_addr[3:2]);
  assign idx = cfg_addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ibp_en <= '0;
    else if (cfg_we && sel == SEL_IBP_EN) ibp_en <= cfg_wdata[NUM_IBP-1:0];
  end

  for (genvar i = 0; i < NUM_IBP; i++) begin : g_ibp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ibp_addr[i] <= '0;
      else if (cfg_we && sel == SEL_IBP_ADDR && idx == 2'(i))
        ibp_addr[i] <= cfg_wdata;
    end
  end

  for (genvar i = 0; i < NUM_DBP; i++) begin : g_dbp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dbp_addr[i] <= '0;
        dbp_ctrl[i] <= '0;
      end else if (cfg_we && idx == 2'(i)) begin
        if (sel == SEL_DBP_ADDR) dbp_addr[i] <= cfg_wdata;
        if (sel == SEL_DBP_CTRL)
          dbp_ctrl[i] <= '{st_en: cfg_wdata[ST_BIT], ld_en: cfg_wdata[LD_BIT],
                           mask: cfg_wdata[MASK_W-1:0]};
      end
    end
  end

  // R3 / R10: enable register holds exactly the low bits written one cycle earlier
  a_r3_enable_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 4'h0) |=> (ibp_en == $past(cfg_wdata[NUM_IBP-1:0])));
endmodule

// File: rtl/dbg_bp_prio.sv
module dbg_bp_prio #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  // R4 / R9: the reported index is a requester, and no lower one is requesting
  a_r4_idx_requesting: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> req[idx]);
  a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((req & ((N'(1) << idx) - N'(1))) == '0));
endmodule

// File: rtl/dbg_dbp_match.sv
module dbg_dbp_match
  import dbg_bp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dbp_ctrl_t         ctrl,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic              mem_valid,
  input  logic              mem_write,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              hit
);
  logic [MASK_W-1:0] fixed;
  logic [ADDR_W-1:0] eff_mask;
  logic              kind_ok;

  // a bit is compared only if it and every field bit above it are set
  assign fixed[MASK_W-1] = ctrl.mask[MASK_W-1];
  for (genvar j = MASK_W - 2; j >= 0; j--) begin : g_cut
    assign fixed[j] = fixed[j+1] & ctrl.mask[j];
  end

  assign eff_mask = {{(ADDR_W-MASK_W){1'b1}}, fixed};
  assign kind_ok  = (ctrl.st_en & mem_write) | (ctrl.ld_en & ~mem_write);
  assign hit      = mem_valid & kind_ok & (((mem_addr ^ bp_addr) & eff_mask) == '0);

  // R5: no kind bit, no hit
  a_r5_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.st_en && !ctrl.ld_en) |-> !hit);
  // R8: the repaired low mask is a high-order run of ones
  a_r8_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({1'b0, ~fixed} + (MASK_W+1)'(1)));
  // R6: an access of the other kind never hits
  a_r6_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mem_write) |-> ctrl.st_en);
endmodule

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit
  import dbg_bp_pkg::*;
#(
  parameter int NUM_IBP = 2,
  parameter int NUM_DBP = 2,
  localparam int IBP_IW = (NUM_IBP > 1) ? $clog2(NUM_IBP) : 1,
  localparam int DBP_IW = (NUM_DBP > 1) ? $clog2(NUM_DBP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              fetch_valid,
  input  logic [31:0]       fetch_addr,
  input  logic              mem_valid,
  input  logic              mem_write,
  input  logic [31:0]       mem_addr,
  output logic              dbg_req,
  output logic              ibp_hit,
  output logic [IBP_IW-1:0] ibp_idx,
  output logic              dbp_hit,
  output logic [DBP_IW-1:0] dbp_idx
);
  logic [NUM_IBP-1:0]             ibp_en;
  logic [NUM_IBP-1:0][ADDR_W-1:0] ibp_addr;
  logic [NUM_DBP-1:0][ADDR_W-1:0] dbp_addr;
  dbp_ctrl_t [NUM_DBP-1:0]        dbp_ctrl;
  logic [NUM_IBP-1:0]             ibp_req;
  logic [NUM_DBP-1:0]             dbp_req;

  dbg_bp_regs #(.NUM_IBP(NUM_IBP), .NUM_DBP(NUM_DBP)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ibp_en(ibp_en), .ibp_addr(ibp_addr),
    .dbp_addr(dbp_addr), .dbp_ctrl(dbp_ctrl)
  );

  for (genvar i = 0; i < NUM_IBP; i++) begin : g_imatch
    assign ibp_req[i] = fetch_valid & ibp_en[i] & (fetch_addr == ibp_addr[i]);
  end

  for (genvar i = 0; i < NUM_DBP; i++) begin : g_dmatch
    dbg_dbp_match u_match (
      .clk(clk), .rst_n(rst_n), .ctrl(dbp_ctrl[i]), .bp_addr(dbp_addr[i]),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .hit(dbp_req[i])
    );
  end

  dbg_bp_prio #(.N(NUM_IBP), .IW(IBP_IW)) u_iprio (
    .clk(clk), .rst_n(rst_n), .req(ibp_req), .hit(ibp_hit), .idx(ibp_idx)
  );
  dbg_bp_prio #(.N(NUM_DBP), .IW(DBP_IW)) u_dprio (
    .clk(clk), .rst_n(rst_n), .req(dbp_req), .hit(dbp_hit), .idx(dbp_idx)
  );

  assign dbg_req = ibp_hit | dbp_hit;

  // R2: no fetch, no instruction hit; R11/R6: no data access, no data hit
  a_r2_fetch_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> !ibp_hit);
  a_r11_data_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> (!dbp_hit && (dbg_req == ibp_hit)));
endmodule

// File: tb/dbg_bp_unit_tb.sv
module dbg_bp_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic fetch_valid = 1'b0, mem_valid = 1'b0, mem_write = 1'b0;
  logic [31:0] fetch_addr = '0, mem_addr = '0;
  logic dbg_req, ibp_hit, dbp_hit;
  logic [0:0] ibp_idx, dbp_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_bp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .dbg_req(dbg_req), .ibp_hit(ibp_hit), .ibp_idx(ibp_idx),
    .dbp_hit(dbp_hit), .dbp_idx(dbp_idx)
  );

  // monitor: samples a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        logic [4:0] e;
        logic [4:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {dbg_req, ibp_hit, ibp_idx, dbp_hit, dbp_idx};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: req/ih/ii/dh/di actual %b expected %b", t, a, e);
        end
      end
    end
  end

  // one cycle: optional write plus an access, with expected outcome queued
  task automatic cycle(input bit we, input logic [3:0] wa, input logic [31:0] wd,
                       input bit fv, input logic [31:0] fa,
                       input bit mv, input bit mw, input logic [31:0] ma,
                       input bit chk, input bit ih, input bit ii,
                       input bit dh, input bit di, input string t);
    @(negedge clk);
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    fetch_valid = fv; fetch_addr = fa;
    mem_valid = mv; mem_write = mw; mem_addr = ma;
    if (chk) begin
      exp_q.push_back({ih | dh, ih, ii, dh, di});
      tag_q.push_back(t);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cycle(1, a, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic acc(input bit fv, input logic [31:0] fa, input bit mv, input bit mw,
                     input logic [31:0] ma, input bit ih, input bit ii,
                     input bit dh, input bit di, input string t);
    cycle(0, 0, 0, fv, fa, mv, mw, ma, 1, ih, ii, dh, di, t);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none

    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state
    acc(1, 32'h0, 1, 1, 32'h0, 0, 0, 0, 0, "R1 reset store");
    acc(1, 32'h0, 1, 0, 32'h0, 0, 0, 0, 0, "R1 reset load");

    // R2: exact fetch match
    wr(4'h4, 32'h0000_1000);
    wr(4'h0, 32'h1);
    acc(1, 32'h1000, 0, 0, 0, 1, 0, 0, 0, "R2 exact hit");
    acc(1, 32'h1001, 0, 0, 0, 0, 0, 0, 0, "R2 off by one");
    acc(0, 32'h1000, 0, 0, 0, 0, 0, 0, 0, "R2 no fetch_valid");

    // R3: upper enable bits dropped
    wr(4'h0, 32'hFFFF_FFFC);
    acc(1, 32'h1000, 0, 0, 0, 0, 0, 0, 0, "R3 high bits arm nothing");

    // R4: lowest instruction index
    wr(4'h5, 32'h0000_1000);
    wr(4'h0, 32'h3);
    acc(1, 32'h1000, 0, 0, 0, 1, 0, 0, 0, "R4 both match idx0");
    wr(4'h0, 32'h2);
    acc(1, 32'h1000, 0, 0, 0, 1, 1, 0, 0, "R4 only idx1");

    // R12: write to a non-existent index changes nothing
    wr(4'h6, 32'h0000_3000);
    acc(1, 32'h3000, 0, 0, 0, 0, 0, 0, 0, "R12 ignored index");
    wr(4'h0, 32'h0);

    // R5: data bp with no kind bits
    wr(4'h8, 32'h0000_4000);
    wr(4'hC, 32'h0000_003F);
    acc(0, 0, 1, 1, 32'h4000, 0, 0, 0, 0, "R5 inactive store");
    acc(0, 0, 1, 0, 32'h4000, 0, 0, 0, 0, "R5 inactive load");

    // R6: store-only then load-only
    wr(4'hC, 32'h8000_003F);
    acc(0, 0, 1, 1, 32'h4000, 0, 0, 1, 0, "R6 store hit");
    acc(0, 0, 1, 0, 32'h4000, 0, 0, 0, 0, "R6 load ignored by store bp");
    wr(4'hC, 32'h4000_003F);
    acc(0, 0, 1, 0, 32'h4000, 0, 0, 1, 0, "R6 load hit");
    acc(0, 0, 1, 1, 32'h4000, 0, 0, 0, 0, "R6 store ignored by load bp");
    acc(0, 0, 0, 0, 32'h4000, 0, 0, 0, 0, "R6 no mem_valid");

    // R7: exact, then 8-byte region
    acc(0, 0, 1, 0, 32'h4001, 0, 0, 0, 0, "R7 full mask bit0");
    wr(4'hC, 32'h4000_0038);
    acc(0, 0, 1, 0, 32'h4007, 0, 0, 1, 0, "R7 region top");
    acc(0, 0, 1, 0, 32'h4008, 0, 0, 0, 0, "R7 region past");
    acc(0, 0, 1, 0, 32'h3FFF, 0, 0, 0, 0, "R7 region below");

    // R8: non-contiguous field 101100 cut to 32-byte block
    wr(4'hC, 32'h4000_002C);
    acc(0, 0, 1, 0, 32'h4008, 0, 0, 1, 0, "R8 bit below cut ignored");
    acc(0, 0, 1, 0, 32'h401F, 0, 0, 1, 0, "R8 block top");
    acc(0, 0, 1, 0, 32'h4020, 0, 0, 0, 0, "R8 next block");

    // R9: lowest data index
    wr(4'h9, 32'h0000_4000);
    wr(4'hD, 32'hC000_003F);
    acc(0, 0, 1, 0, 32'h4000, 0, 0, 1, 0, "R9 both match idx0");
    acc(0, 0, 1, 0, 32'h4010, 0, 0, 1, 0, "R9 only idx0 region");
    wr(4'hC, 32'h0);
    acc(0, 0, 1, 1, 32'h4000, 0, 0, 1, 1, "R9 idx1 alone");

    // R10: write takes effect next cycle
    cycle(1, 4'h9, 32'h0000_5000, 0, 0, 1, 1, 32'h5000, 1, 0, 0, 0, 0, "R10 same cycle old value");
    acc(0, 0, 1, 1, 32'h5000, 0, 0, 1, 1, "R10 next cycle new value");

    // R11: both causes at once
    wr(4'h0, 32'h1);
    acc(1, 32'h1000, 1, 0, 32'h5000, 1, 0, 1, 1, "R11 both causes");

    acc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 idle");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule